// File: doc/BRIEF.md
# Selectable-Clock Timer Channel

A single 16-bit up-counting timer channel. A control field picks the count step source at run time: the system clock, a divided system clock (/2, /4, /8), or one of four external clock pins. The external pins are synchronized, and another field chooses whether their rising edges, falling edges or both advance the counter. A phase-counting override flag takes the counter away from these selections, and the counter then advances on a step input supplied by phase-decoding logic elsewhere.

Two general registers, A and B, sit beside the counter. Each one is set independently as an output compare, which signals when the counter steps while equal to it, or as an input capture, which latches the counter on a rising edge of its capture pin. A clear field decides what returns the counter to zero: nothing, an event on A, an event on B, or a clear shared across a group of channels. The shared clear works only while the channel's synchronization enable is high. In that case any event on A or B in this channel raises a request to the peer channels, and a request from a peer clears this counter.

Top module: `timer_channel`

## Requirements
- R1: After reset the counter is 0, both general registers are 0xFFFF, both flags are 0, both general registers are in compare mode, and the control register is 0: system clock, rising edge, no clear.
- R2: The control register is written at address 0. Data bits [2:0] select the source: 0 is every cycle, 1 is every 2nd, 2 is every 4th and 3 is every 8th cycle of a free-running divider. The counter rises by exactly 1 per step.
- R3: Source values 4, 5, 6 and 7 select ext_clk_i bits 0, 1, 2 and 3. Each pin passes through two synchronizing flops. A pin edge placed between clock edges changes the counter after the third following rising clock edge. Pins that are not selected have no effect.
- R4: Control bits [4:3] choose the external edge: 0 counts rising edges, 1 counts falling edges, and 2 or 3 counts both.
- R5: While phase_mode_i is 1, the counter advances on exactly the cycles where phase_step_i is 1, whatever the source and edge fields hold.
- R6: A general register in compare mode raises an event when a count step happens while the counter equals it. Its flag_o bit is 1 for the one cycle after the event.
- R7: Control bits [6:5] select the clear. 1 means A events, 2 means B events. A clearing compare event loads 0 in place of the increment.
- R8: A general register in capture mode detects a rising edge of its synchronized capture pin (cap_i bit 0 for A, bit 1 for B) two clock edges after the pin rises. On the next edge it latches the counter, its flag goes high, and if it is the clear source the counter becomes 0 on that same edge.
- R9: Clear value 3 with sync_en_i high is synchronous mode. sync_clr_i clears the counter on the next edge. Any A or B event drives sync_clr_o high in the same cycle and clears this counter. With sync_en_i low, mode 3 clears nothing and sync_clr_o stays 0.
- R10: Address 1 writes A, address 2 writes B, and address 3 bits [1:0] pick capture mode (1) or compare mode (0) for A and B. A capture on the same edge as a write to that register wins.
- R11: With no clear, a step from 0xFFFF gives 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_clk_i | input | 4 | External clock pins |
| cap_i | input | 2 | Capture pins for A (bit 0) and B (bit 1) |
| phase_mode_i | input | 1 | Phase-counting override |
| phase_step_i | input | 1 | Count step while the override is active |
| sync_en_i | input | 1 | Channel belongs to the synchronized group |
| sync_clr_i | input | 1 | Clear request from peer channels |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 16 | Register write data |
| cnt_o | output | 16 | Counter value |
| gra_o | output | 16 | General register A |
| grb_o | output | 16 | General register B |
| flag_o | output | 2 | Event flags for A (bit 0) and B (bit 1) |
| sync_clr_o | output | 1 | Clear request to peer channels |

## Verification
The counter, the general registers and the flags change on the edge right after the cycle whose count step, event or write causes them. sync_clr_o is combinational and is due in that same cycle. External clock edges reach the counter after the third edge, and capture pins after the third edge as well. The reference model holds its own copies of the two synchronizer stages and the divider, so each of these delays falls out of the model with no special case. Every output is compared at the falling clock edge, after the rising edge has settled. Directed checks read results only after counting those edges.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int SRC_W = 3;

  typedef enum logic [1:0] {
    CLR_NONE = 2'd0,
    CLR_A    = 2'd1,
    CLR_B    = 2'd2,
    CLR_SYNC = 2'd3
  } clr_mode_e;

  typedef enum logic [1:0] {
    EDGE_RISE  = 2'd0,
    EDGE_FALL  = 2'd1,
    EDGE_BOTH  = 2'd2,
    EDGE_BOTH2 = 2'd3
  } edge_sel_e;

  typedef struct packed {
    clr_mode_e        clr;
    edge_sel_e        edg;
    logic [SRC_W-1:0] src;
  } ctrl_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_GRA  = 2'd1;
  localparam logic [1:0] ADDR_GRB  = 2'd2;
  localparam logic [1:0] ADDR_IOS  = 2'd3;
endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign cur_o  = s2_q;
  assign prev_o = s3_q;
endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
  import timer_pkg::*;
#(
  parameter int N_EXT      = 4,
  parameter int DIV_STAGES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EXT-1:0] ext_i,
  input  logic [SRC_W-1:0] src_i,
  input  logic [1:0]       edge_i,
  input  logic             phase_mode_i,
  input  logic             phase_step_i,
  output logic             tick_o
);
  localparam int DIV_W = DIV_STAGES - 1;

  logic [DIV_W-1:0]      div_q;
  logic [DIV_STAGES-1:0] div_en;
  logic [N_EXT-1:0]      ext_cur, ext_prev, ext_rise, ext_fall, ext_hit;
  logic                  int_tick, ext_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  assign div_en[0] = 1'b1;
  for (genvar k = 1; k < DIV_STAGES; k++) begin : g_div
    assign div_en[k] = &div_q[k-1:0];
  end

  tmr_sync_edge #(.W(N_EXT)) u_ext_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ext_i),
    .cur_o (ext_cur),
    .prev_o(ext_prev)
  );

  assign ext_rise = ext_cur & ~ext_prev;
  assign ext_fall = ~ext_cur & ext_prev;
  assign ext_hit  = edge_i[1] ? (ext_rise | ext_fall)
                  : (edge_i[0] ? ext_fall : ext_rise);

  always_comb begin
    int_tick = 1'b0;
    ext_tick = 1'b0;
    for (int k = 0; k < DIV_STAGES; k++)
      if (src_i == SRC_W'(k)) int_tick = div_en[k];
    for (int k = 0; k < N_EXT; k++)
      if (src_i == SRC_W'(DIV_STAGES + k)) ext_tick = ext_hit[k];
  end

  // phase override wins over source and edge selection
  assign tick_o = phase_mode_i ? phase_step_i : (int_tick | ext_tick);
endmodule

// File: rtl/tmr_gr_unit.sv
module tmr_gr_unit #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         cap_mode_i,
  input  logic         cap_rise_i,
  input  logic         tick_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] gr_o,
  output logic         cap_evt_o,
  output logic         evt_o,
  output logic         flag_o
);
  logic [W-1:0] gr_q;
  logic         flag_q, cmp_evt;

  assign cap_evt_o = cap_mode_i & cap_rise_i;
  assign cmp_evt   = ~cap_mode_i & tick_i & (cnt_i == gr_q);
  assign evt_o     = cap_evt_o | cmp_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gr_q   <= '1;
      flag_q <= 1'b0;
    end else begin
      flag_q <= evt_o;
      if (cap_evt_o) gr_q <= cnt_i;
      else if (wr_i) gr_q <= wr_data_i;
    end
  end

  assign gr_o   = gr_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/timer_channel.sv
module timer_channel
  import timer_pkg::*;
#(
  parameter int W          = 16,
  parameter int N_EXT      = 4,
  parameter int DIV_STAGES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EXT-1:0] ext_clk_i,
  input  logic [1:0]       cap_i,
  input  logic             phase_mode_i,
  input  logic             phase_step_i,
  input  logic             sync_en_i,
  input  logic             sync_clr_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [W-1:0]     wr_data_i,
  output logic [W-1:0]     cnt_o,
  output logic [W-1:0]     gra_o,
  output logic [W-1:0]     grb_o,
  output logic [1:0]       flag_o,
  output logic             sync_clr_o
);
  localparam int NGR    = 2;
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t          ctrl_q;
  logic [NGR-1:0] ios_q;
  logic [W-1:0]   cnt_q;
  logic           tick;
  logic [NGR-1:0] cap_cur, cap_prev, cap_rise, cap_evt, evt, gr_wr;
  logic [W-1:0]   gr [NGR];
  logic           sync_act, own_clr, clr_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ios_q  <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_CTRL) ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
      if (wr_addr_i == ADDR_IOS)  ios_q  <= wr_data_i[NGR-1:0];
    end
  end

  tmr_tick_gen #(.N_EXT(N_EXT), .DIV_STAGES(DIV_STAGES)) u_tick (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ext_i       (ext_clk_i),
    .src_i       (ctrl_q.src),
    .edge_i      (ctrl_q.edg),
    .phase_mode_i(phase_mode_i),
    .phase_step_i(phase_step_i),
    .tick_o      (tick)
  );

  tmr_sync_edge #(.W(NGR)) u_cap_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cap_i),
    .cur_o (cap_cur),
    .prev_o(cap_prev)
  );
  assign cap_rise = cap_cur & ~cap_prev;

  assign gr_wr[0] = wr_en_i & (wr_addr_i == ADDR_GRA);
  assign gr_wr[1] = wr_en_i & (wr_addr_i == ADDR_GRB);

  for (genvar g = 0; g < NGR; g++) begin : g_gr
    tmr_gr_unit #(.W(W)) u_gr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (gr_wr[g]),
      .wr_data_i (wr_data_i),
      .cap_mode_i(ios_q[g]),
      .cap_rise_i(cap_rise[g]),
      .tick_i    (tick),
      .cnt_i     (cnt_q),
      .gr_o      (gr[g]),
      .cap_evt_o (cap_evt[g]),
      .evt_o     (evt[g]),
      .flag_o    (flag_o[g])
    );
  end

  // clear arbitration
  assign sync_act = (ctrl_q.clr == CLR_SYNC) & sync_en_i;
  always_comb begin
    unique case (ctrl_q.clr)
      CLR_A:    own_clr = evt[0];
      CLR_B:    own_clr = evt[1];
      CLR_SYNC: own_clr = sync_en_i & (|evt);
      default:  own_clr = 1'b0;
    endcase
  end
  assign clr_now    = own_clr | (sync_act & sync_clr_i);
  assign sync_clr_o = sync_act & own_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_now) cnt_q <= '0;
    else if (tick)    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
  assign gra_o = gr[0];
  assign grb_o = gr[1];
endmodule

// File: rtl/timer_channel_chk.sv
module timer_channel_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] cnt_i,
  input logic [W-1:0] gra_i,
  input logic [1:0]   flag_i,
  input logic [1:0]   cap_evt_i,
  input logic [1:0]   evt_i,
  input logic         tick_i,
  input logic [1:0]   clr_mode_i,
  input logic         sync_en_i,
  input logic         sync_clr_i,
  input logic         sync_req_i,
  input logic         phase_mode_i,
  input logic         phase_step_i
);
  AST_STEP_OR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != $past(cnt_i)) |-> (cnt_i == $past(cnt_i) + 1'b1 || cnt_i == '0)); // R2

  AST_PHASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_mode_i && !phase_step_i && clr_mode_i == 2'd0) |=> $stable(cnt_i)); // R5

  AST_FLAG_FOLLOWS_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_i[0] |-> $past(evt_i[0])); // R6

  AST_CAPTURE_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt_i[0] |=> (gra_i == $past(cnt_i))); // R8

  AST_SYNC_REQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_req_i |-> (clr_mode_i == 2'd3 && sync_en_i)); // R9

  AST_PEER_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_mode_i == 2'd3 && sync_en_i && sync_clr_i) |=> (cnt_i == '0)); // R9

  AST_NO_CLR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_mode_i == 2'd0 && tick_i && cnt_i == '1) |=> (cnt_i == '0)); // R11
endmodule

bind timer_channel timer_channel_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cnt_i       (cnt_o),
  .gra_i       (gra_o),
  .flag_i      (flag_o),
  .cap_evt_i   (cap_evt),
  .evt_i       (evt),
  .tick_i      (tick),
  .clr_mode_i  (ctrl_q.clr),
  .sync_en_i   (sync_en_i),
  .sync_clr_i  (sync_clr_i),
  .sync_req_i  (sync_clr_o),
  .phase_mode_i(phase_mode_i),
  .phase_step_i(phase_step_i)
);

// File: tb/timer_channel_test.sv
`timescale 1ns/1ps
module timer_channel_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  ext = '0;
  logic [1:0]  cap = '0;
  logic        phase_mode = 0, phase_step = 0, sync_en = 0, sync_clr = 0;
  logic        wr_en = 0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] cnt, gra, grb;
  logic [1:0]  flag;
  logic        sync_req;

  int errors = 0, checks = 0;
  bit done = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  timer_channel uut (
    .clk_i(clk), .rst_ni(rst_n), .ext_clk_i(ext), .cap_i(cap),
    .phase_mode_i(phase_mode), .phase_step_i(phase_step),
    .sync_en_i(sync_en), .sync_clr_i(sync_clr),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .cnt_o(cnt), .gra_o(gra), .grb_o(grb), .flag_o(flag), .sync_clr_o(sync_req)
  );

  // reference model state
  logic [15:0] m_cnt, m_gr0, m_gr1;
  logic [2:0]  m_div, m_src;
  logic [1:0]  m_edge, m_clr, m_io, m_flag;
  logic [3:0]  e1, e2, e3;
  logic [1:0]  c1, c2, c3;

  function automatic logic m_tick();
    int k;
    logic r, f;
    if (phase_mode) return phase_step;
    case (m_src)
      3'd0: return 1'b1;
      3'd1: return m_div[0];
      3'd2: return &m_div[1:0];
      3'd3: return &m_div;
      default: begin
        k = int'(m_src) - 4;
        r = e2[k] & ~e3[k];
        f = ~e2[k] & e3[k];
        if (m_edge == 2'd0) return r;
        if (m_edge == 2'd1) return f;
        return r | f;
      end
    endcase
  endfunction

  function automatic logic m_evt(int i);
    logic [15:0] g;
    g = (i == 0) ? m_gr0 : m_gr1;
    if (m_io[i]) return c2[i] & ~c3[i];
    return m_tick() & (m_cnt == g);
  endfunction

  function automatic logic m_own();
    if (m_clr == 2'd1) return m_evt(0);
    if (m_clr == 2'd2) return m_evt(1);
    if (m_clr == 2'd3 && sync_en) return m_evt(0) | m_evt(1);
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0; m_gr0 <= '1; m_gr1 <= '1; m_div <= '0; m_src <= '0;
      m_edge <= '0; m_clr <= '0; m_io <= '0; m_flag <= '0;
      e1 <= '0; e2 <= '0; e3 <= '0; c1 <= '0; c2 <= '0; c3 <= '0;
    end else begin
      logic t, ev0, ev1, clr, cap0, cap1;
      t    = m_tick();
      ev0  = m_evt(0);
      ev1  = m_evt(1);
      cap0 = m_io[0] & c2[0] & ~c3[0];
      cap1 = m_io[1] & c2[1] & ~c3[1];
      clr  = m_own() | (m_clr == 2'd3 && sync_en && sync_clr);
      m_cnt  <= clr ? 16'd0 : (t ? m_cnt + 16'd1 : m_cnt);
      m_flag <= {ev1, ev0};
      if (cap0) m_gr0 <= m_cnt;
      else if (wr_en && wr_addr == 2'd1) m_gr0 <= wr_data;
      if (cap1) m_gr1 <= m_cnt;
      else if (wr_en && wr_addr == 2'd2) m_gr1 <= wr_data;
      if (wr_en && wr_addr == 2'd0) begin
        m_src <= wr_data[2:0]; m_edge <= wr_data[4:3]; m_clr <= wr_data[6:5];
      end
      if (wr_en && wr_addr == 2'd3) m_io <= wr_data[1:0];
      m_div <= m_div + 3'd1;
      e1 <= ext; e2 <= e1; e3 <= e2;
      c1 <= cap; c2 <= c1; c3 <= c2;
    end
  end

  task automatic chk(string t, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", t, got, exp, $time);
    end
  endtask

  // per-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({tag, " cnt"}, cnt, m_cnt);
      chk({tag, " gra"}, gra, m_gr0);
      chk({tag, " grb"}, grb, m_gr1);
      chk({tag, " flag"}, {14'd0, flag}, {14'd0, m_flag});
      chk({tag, " sync_clr_o"}, {15'd0, sync_req}, {15'd0, m_clr == 2'd3 && sync_en && m_own()});
    end
  end

  task automatic cyc(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    cyc(1);
    wr_en = 0;
  endtask

  task automatic zero_cnt(logic [15:0] ctrl_after);
    wr(2'd0, 16'h0060);
    sync_en = 1; sync_clr = 1;
    cyc(1);
    chk("R9 peer clear", cnt, 16'd0);
    sync_clr = 0; sync_en = 0;
    wr(2'd0, ctrl_after);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [15:0] c0;
    int seen;
    cyc(3);
    rst_n = 1;
    cyc(1);
    tag = "R1";
    chk("R1 cnt", cnt, 16'd1);  // one system-clock step after release
    chk("R1 gra", gra, 16'hFFFF);
    chk("R1 grb", grb, 16'hFFFF);
    chk("R1 flag", {14'd0, flag}, 16'd0);

    tag = "R2";
    cyc(20);
    foreach (m_div[i]) begin end
    for (int s = 1; s < 4; s++) begin
      wr(2'd0, 16'(s));
      cyc(40);
    end
    c0 = cnt;
    cyc(16);
    chk("R2 div8", cnt, c0 + 16'd2);

    tag = "R3";
    for (int s = 4; s < 8; s++) begin
      wr(2'd0, 16'h0010 | 16'(s));
      for (int j = 0; j < 8; j++) begin ext = ext ^ 4'hF; cyc(4); end
    end
    wr(2'd0, 16'h0015);
    cyc(4);
    c0 = cnt;
    for (int j = 0; j < 6; j++) begin ext[1] = ~ext[1]; ext[0] = ~ext[0]; cyc(4); end
    cyc(4);
    chk("R3 pin B both edges", cnt, c0 + 16'd6);
    c0 = cnt;
    for (int j = 0; j < 4; j++) begin ext[2] = ~ext[2]; cyc(4); end
    chk("R3 unselected pin", cnt, c0);

    tag = "R4";
    wr(2'd0, 16'h0005);
    c0 = cnt;
    for (int j = 0; j < 6; j++) begin ext[1] = ~ext[1]; cyc(4); end
    chk("R4 rising only", cnt, c0 + 16'd3);
    wr(2'd0, 16'h000D);
    c0 = cnt;
    for (int j = 0; j < 6; j++) begin ext[1] = ~ext[1]; cyc(4); end
    chk("R4 falling only", cnt, c0 + 16'd3);

    tag = "R5";
    phase_mode = 1;
    c0 = cnt;
    for (int j = 0; j < 5; j++) begin
      phase_step = 1; ext[1] = ~ext[1]; cyc(1);
      phase_step = 0; cyc(3);
    end
    chk("R5 phase override", cnt, c0 + 16'd5);
    phase_mode = 0;

    tag = "R11";
    wr(2'd1, 16'h0010);
    wr(2'd0, 16'h0000);
    c0 = cnt;
    cyc(65540);
    chk("R11 wrap", cnt, c0 + 16'd4);

    tag = "R7";
    zero_cnt(16'h0000);
    wr(2'd1, 16'd20);
    wr(2'd0, 16'h0020);
    cyc(100);
    chk("R7 clear on A", {15'd0, cnt <= 16'd20}, 16'd1);
    zero_cnt(16'h0000);
    wr(2'd2, 16'd7);
    wr(2'd0, 16'h0040);
    cyc(30);
    chk("R7 clear on B", {15'd0, cnt <= 16'd7}, 16'd1);

    tag = "R8";
    wr(2'd3, 16'h0001);
    wr(2'd0, 16'h0020);
    cyc(10);
    c0 = cnt;
    cap[0] = 1; cyc(1); cap[0] = 0; cyc(2);
    chk("R8 capture value", gra, c0 + 16'd2);
    chk("R8 capture clear", cnt, 16'd0);
    chk("R8 capture flag", {14'd0, flag}, 16'd1);

    tag = "R10";
    wr(2'd3, 16'h0003);
    cyc(5);
    c0 = cnt;
    cap[1] = 1; cyc(1); cap[1] = 0; cyc(1);
    wr(2'd2, 16'h1234);
    chk("R10 capture beats write", grb, c0 + 16'd2);
    wr(2'd2, 16'h5555);
    chk("R10 plain write", grb, 16'h5555);

    tag = "R6";
    wr(2'd3, 16'h0000);
    zero_cnt(16'h0000);
    wr(2'd1, 16'd30);
    seen = 0;
    for (int j = 0; j < 40; j++) begin cyc(1); if (flag[0]) seen++; end
    chk("R6 single compare flag", 16'(seen), 16'd1);

    tag = "R9";
    zero_cnt(16'h0000);
    wr(2'd1, 16'd6);
    wr(2'd0, 16'h0060);
    sync_en = 1;
    seen = 0;
    for (int j = 0; j < 20; j++) begin @(negedge clk); if (sync_req) seen++; #1; end
    chk("R9 own request seen", {15'd0, seen > 0}, 16'd1);
    sync_en = 0;
    cyc(2);
    c0 = cnt;
    sync_clr = 1; cyc(1); sync_clr = 0;
    chk("R9 ignored without enable", cnt, c0 + 16'd1);

    cyc(5);
    finish_run();
  end
endmodule